// File: doc/BRIEF.md
# Keyboard and Watchdog System Reset Generator

This block drives the active-low system reset line of a small computer from logic clocked by the bus E clock. It holds reset low for a short, fixed time after its own logic starts. After that it produces one reset pulse of the same length each time the keyboard controller lowers its request line. It also produces a pulse when an armed watchdog times out because software has stopped writing the kick location.

The keyboard controller sits on the reset line it requests. For that reason every pulse ends by itself after a counted number of E clock cycles, and no acknowledge is needed. The keyboard request is asynchronous and passes through a synchroniser before its falling edge is detected. Every pulse also disarms and clears the watchdog, so software has to arm it again after each reset.

Top module: `rstgen_top`

## Requirements
- R1: While `rst_ni` is low, `sys_rst_no` is low. After `rst_ni` rises, `sys_rst_no` stays low until the PULSE_LEN-th (default 16) rising clock edge and is high from that edge on.
- R2: A high-to-low transition of `kbd_req_ni` outside a pulse drives `sys_rst_no` low after the third rising edge that samples the new level. It stays low for exactly PULSE_LEN clock cycles and then goes high.
- R3: A keyboard request held low gives only one pulse, and a low-to-high transition of `kbd_req_ni` gives no pulse.
- R4: A falling edge of `kbd_req_ni` detected while a pulse is running is ignored. It neither lengthens the pulse nor starts a new one afterwards.
- R5: After any reset the watchdog is disarmed, and no amount of time without kicks produces a pulse.
- R6: When `wdt_arm_i` is high at a clock edge, the watchdog is armed. With no kick, `sys_rst_no` goes low after the WDT_TIMEOUT-th rising edge following the arming edge, for PULSE_LEN cycles.
- R7: When `wdt_kick_i` is high at a clock edge, the watchdog count restarts from zero, so expiry comes WDT_TIMEOUT edges after the last kick.
- R8: Every pulse, whatever its source, disarms the watchdog and clears its count, so no further pulse follows without a new arm.
- R9: `wdt_arm_i` asserted while a pulse is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | E clock |
| rst_ni | input | 1 | Asynchronous active-low start-up reset (low until the logic is configured) |
| kbd_req_ni | input | 1 | Asynchronous active-low keyboard reset request |
| wdt_kick_i | input | 1 | One-cycle strobe from a write to the kick location |
| wdt_arm_i | input | 1 | One-cycle strobe from a write that arms the watchdog |
| sys_rst_no | output | 1 | Active-low system reset |

## Verification
The keyboard path is driven with a single falling edge, a request held low, a release, and a second falling edge placed inside a running pulse. Together these separate edge detection from level detection and show whether a pulse can be extended. The watchdog is left unarmed, armed with no kicks, armed with a late kick, armed and then overtaken by a keyboard pulse, and armed during a pulse. These cases tell apart the timeout length, restart on kick, disarm on every reset and the masking of arm writes during reset. Every pulse is timed from the stimulus edge to its falling and rising edges, so an off-by-one in the synchroniser or either counter changes a measured number.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
  typedef enum logic {
    PH_RUN  = 1'b0,
    PH_HOLD = 1'b1
  } phase_e;
endpackage

// File: rtl/rstgen_sync.sv
module rstgen_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= {STAGES{RST_VAL}};
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/rstgen_pulse.sv
module rstgen_pulse
  import rstgen_pkg::*;
#(
  parameter int LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic active_o
);
  localparam int LEN_W = (LEN > 2) ? $clog2(LEN) : 1;
  localparam logic [LEN_W-1:0] LAST = LEN_W'(LEN - 1);

  phase_e           phase;
  logic [LEN_W-1:0] cnt;

  // Starts in HOLD so reset is asserted straight out of configuration.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase <= PH_HOLD;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_HOLD: begin
          if (cnt == LAST) begin
            phase <= PH_RUN;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_RUN: if (trig_i) phase <= PH_HOLD;
        default: phase <= PH_HOLD;
      endcase
    end
  end

  assign active_o = (phase == PH_HOLD);
endmodule

// File: rtl/rstgen_wdt.sv
module rstgen_wdt #(
  parameter int TIMEOUT = 10_000_000
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clear_i,
  input  logic                         arm_i,
  input  logic                         kick_i,
  output logic                         en_o,
  output logic [$clog2(TIMEOUT)-1:0]   cnt_o,
  output logic                         expire_o
);
  localparam int CNT_W = $clog2(TIMEOUT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  logic             en;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en  <= 1'b0;
      cnt <= '0;
    end else if (clear_i) begin
      en  <= 1'b0;
      cnt <= '0;
    end else begin
      if (arm_i) en <= 1'b1;
      if (!en || kick_i || cnt == LAST) cnt <= '0;
      else                              cnt <= cnt + 1'b1;
    end
  end

  assign en_o     = en;
  assign cnt_o    = cnt;
  assign expire_o = en && !kick_i && (cnt == LAST);
endmodule

// File: rtl/rstgen_top.sv
module rstgen_top #(
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_LEN   = 16,
  parameter int WDT_TIMEOUT = 10_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kbd_req_ni,
  input  logic wdt_kick_i,
  input  logic wdt_arm_i,
  output logic sys_rst_no
);
  localparam int CNT_W = $clog2(WDT_TIMEOUT);

  logic             kbd_sync;
  logic             kbd_prev;
  logic             kbd_fall;
  logic             wdt_en;
  logic [CNT_W-1:0] wdt_cnt;
  logic             wdt_expire;
  logic             pulse_active;

  rstgen_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (kbd_req_ni),
    .q_o   (kbd_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) kbd_prev <= 1'b1;
    else         kbd_prev <= kbd_sync;
  end

  assign kbd_fall = kbd_prev && !kbd_sync;

  rstgen_wdt #(.TIMEOUT(WDT_TIMEOUT)) u_wdt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (pulse_active),
    .arm_i   (wdt_arm_i),
    .kick_i  (wdt_kick_i),
    .en_o    (wdt_en),
    .cnt_o   (wdt_cnt),
    .expire_o(wdt_expire)
  );

  rstgen_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (kbd_fall || wdt_expire),
    .active_o(pulse_active)
  );

  assign sys_rst_no = !pulse_active;
endmodule

// File: rtl/rstgen_checker.sv
module rstgen_checker #(
  parameter int PULSE_LEN   = 16,
  parameter int WDT_TIMEOUT = 10_000_000
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           sys_rst_no,
  input logic                           kbd_fall,
  input logic                           wdt_en,
  input logic [$clog2(WDT_TIMEOUT)-1:0] wdt_cnt
);
  localparam int CNT_W = $clog2(WDT_TIMEOUT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WDT_TIMEOUT - 1);

  int unsigned low_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          low_len <= 0;
    else if (!sys_rst_no) low_len <= low_len + 1;
    else                  low_len <= 0;
  end

  a_r4_len_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_len <= PULSE_LEN);

  a_r2_full_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_no) |-> low_len == PULSE_LEN);

  a_r3_single_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kbd_fall |=> !kbd_fall);

  a_r8_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_rst_no |=> !wdt_en);

  a_r5_idle_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wdt_en |=> wdt_cnt == '0);

  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_cnt <= LAST);
endmodule

bind rstgen_top rstgen_checker #(
  .PULSE_LEN  (PULSE_LEN),
  .WDT_TIMEOUT(WDT_TIMEOUT)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sys_rst_no(sys_rst_no),
  .kbd_fall  (kbd_fall),
  .wdt_en    (wdt_en),
  .wdt_cnt   (wdt_cnt)
);

// File: tb/rstgen_top_bench.sv
module rstgen_top_bench;
  localparam int PERIOD = 10;
  localparam int PLEN   = 16;
  localparam int T      = 40;
  localparam int IDLE   = 3 * T;

  logic clk = 1'b0;
  logic rst_ni, kbd_req_ni, wdt_kick_i, wdt_arm_i;
  logic sys_rst_no;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  rstgen_top #(.SYNC_STAGES(2), .PULSE_LEN(PLEN), .WDT_TIMEOUT(T)) u_rstgen_top (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .kbd_req_ni(kbd_req_ni),
    .wdt_kick_i(wdt_kick_i),
    .wdt_arm_i (wdt_arm_i),
    .sys_rst_no(sys_rst_no)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // hi: negedges sampled high before the pulse, lo: negedges sampled low
  task automatic measure(input int limit, output int hi, output int lo);
    hi = 0;
    lo = 0;
    while (sys_rst_no && hi < limit) begin @(negedge clk); hi++; end
    if (hi < limit)
      while (!sys_rst_no && lo < limit) begin @(negedge clk); lo++; end
  endtask

  task automatic t_powerup();
    int hi, lo;
    repeat (3) @(negedge clk);
    check(!sys_rst_no, "R1 low in reset", sys_rst_no, 0);
    rst_ni = 1'b1;
    measure(100, hi, lo);
    check(hi == 0, "R1 start delay", hi, 0);
    check(lo == PLEN, "R1 hold length", lo, PLEN);
  endtask

  task automatic t_unarmed();
    int hi, lo;
    measure(IDLE, hi, lo);
    check(hi == IDLE, "R5 no expiry while disarmed", hi, IDLE);
  endtask

  task automatic t_kbd_basic();
    int hi, lo;
    kbd_req_ni = 1'b0;
    measure(100, hi, lo);
    check(hi == 3, "R2 kbd latency", hi, 3);
    check(lo == PLEN, "R2 kbd pulse length", lo, PLEN);
    measure(40, hi, lo);
    check(hi == 40, "R3 held low no retrigger", hi, 40);
    kbd_req_ni = 1'b1;
    measure(40, hi, lo);
    check(hi == 40, "R3 rising edge no pulse", hi, 40);
  endtask

  task automatic t_kbd_in_pulse();
    int hi, lo;
    kbd_req_ni = 1'b0;
    repeat (5) @(negedge clk);
    kbd_req_ni = 1'b1;
    repeat (4) @(negedge clk);
    kbd_req_ni = 1'b0;
    repeat (9) @(negedge clk);
    check(!sys_rst_no, "R4 still low at end", sys_rst_no, 0);
    @(negedge clk);
    check(sys_rst_no, "R4 not extended", sys_rst_no, 1);
    measure(40, hi, lo);
    check(hi == 40, "R4 no later pulse", hi, 40);
    kbd_req_ni = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_wdt_expire();
    int hi, lo;
    wdt_arm_i = 1'b1;
    @(negedge clk);
    wdt_arm_i = 1'b0;
    measure(IDLE, hi, lo);
    check(hi == T, "R6 timeout", hi, T);
    check(lo == PLEN, "R6 pulse length", lo, PLEN);
    measure(IDLE, hi, lo);
    check(hi == IDLE, "R8 disarmed after wdt pulse", hi, IDLE);
  endtask

  task automatic t_wdt_kick();
    int hi, lo;
    wdt_arm_i = 1'b1;
    @(negedge clk);
    wdt_arm_i = 1'b0;
    repeat (T - 5) @(negedge clk);
    check(sys_rst_no, "R7 no reset before kick", sys_rst_no, 1);
    wdt_kick_i = 1'b1;
    @(negedge clk);
    wdt_kick_i = 1'b0;
    measure(IDLE, hi, lo);
    check(hi == T, "R7 timeout from kick", hi, T);
    check(lo == PLEN, "R7 pulse length", lo, PLEN);
  endtask

  task automatic t_kbd_disarms();
    int hi, lo;
    wdt_arm_i = 1'b1;
    @(negedge clk);
    wdt_arm_i = 1'b0;
    repeat (5) @(negedge clk);
    kbd_req_ni = 1'b0;
    measure(100, hi, lo);
    check(hi == 3, "R8 kbd latency", hi, 3);
    check(lo == PLEN, "R8 kbd pulse length", lo, PLEN);
    kbd_req_ni = 1'b1;
    measure(IDLE, hi, lo);
    check(hi == IDLE, "R8 kbd pulse disarms", hi, IDLE);
  endtask

  task automatic t_arm_in_pulse();
    int hi, lo;
    kbd_req_ni = 1'b0;
    repeat (6) @(negedge clk);
    check(!sys_rst_no, "R9 pulse running", sys_rst_no, 0);
    wdt_arm_i = 1'b1;
    @(negedge clk);
    wdt_arm_i  = 1'b0;
    kbd_req_ni = 1'b1;
    measure(100, hi, lo);
    check(lo == PLEN - 4, "R9 remaining pulse", lo, PLEN - 4);
    measure(IDLE, hi, lo);
    check(hi == IDLE, "R9 arm ignored", hi, IDLE);
  endtask

  initial begin
    rst_ni     = 1'b0;
    kbd_req_ni = 1'b1;
    wdt_kick_i = 1'b0;
    wdt_arm_i  = 1'b0;
    t_powerup();
    t_unarmed();
    t_kbd_basic();
    t_kbd_in_pulse();
    t_wdt_expire();
    t_wdt_kick();
    t_kbd_disarms();
    t_arm_in_pulse();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule